// File: doc/BRIEF.md
# Interrupt Source Destination Router

The router sits between the per-source state of a multi-core interrupt controller and the per-CPU interrupt lines. Each interrupt source owns a 32-bit destination word. The word is written through a small write port. Every write is masked and decoded at once into two things: a bitmap of target CPUs and an output class, which is either normal or critical. The decoded form is what the delivery logic uses afterwards.

When a source raises its pending strobe, the router delivers it using the decoded state. In directed mode it goes to every CPU in the bitmap. In distributed mode it goes to exactly one CPU, chosen round-robin after the CPU that source last served. A normal delivery is suppressed at a CPU whose current task priority is at or above the source priority. A critical delivery skips the priority check, drives the CPU's critical line and raises the source's activity pulse. All outputs are registered one-cycle pulses. Pulses from several sources in the same cycle are ORed per CPU.

Top module: `irq_dest_router`

## Requirements
- R1: After reset every bitmap is empty, every last-served index is 0 and every class is normal. All outputs are low, and a pending strobe on an unwritten source delivers nothing.
- R2: A write keeps only bits [N-1:0], the critical field [30:31-N] and bit 31. Any other bit set in the write data has no effect on delivery.
- R3: Critical-field bit 30-i selects CPU i. When any critical-field bit is set, the class is critical and delivery drives crit_o[i] for each selected CPU.
- R4: When a critical-field bit is set, the normal bits [N-1:0] of the same word are ignored.
- R5: When no critical-field bit is set, the class is normal and bit i of [N-1:0] selects CPU i on int_o.
- R6: A critical delivery ignores task priority, and it pulses crit_act_o for that source in the same cycle as crit_o.
- R7: A normal delivery to CPU c is suppressed when the source priority is less than or equal to task_prio of CPU c.
- R8: With mode bit 0 (directed), a source is delivered to every CPU in its bitmap. Pulses from sources pending in the same cycle are ORed per CPU.
- R9: With mode bit 1 (distributed), a source goes to the first bitmap CPU found searching upward from last-served+1 and wrapping at N. That CPU becomes the last-served index.
- R10: A distributed source with an empty bitmap delivers nothing and leaves its last-served index unchanged.
- R11: Outputs appear on the clock edge that samples the pending strobe and last exactly one cycle. With no strobe pending, all outputs are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Destination word write strobe |
| wr_src_i | input | SRC_W | Source index being written |
| wr_data_i | input | 32 | Destination word value |
| pend_i | input | NUM_SRC | Per-source pending strobe |
| mode_i | input | NUM_SRC | Per-source delivery mode, 1 = distributed |
| prio_i | input | NUM_SRC*PRIO_W | Per-source priority, source s in slice s |
| task_prio_i | input | NUM_CPU*PRIO_W | Per-CPU current task priority, CPU c in slice c |
| int_o | output | NUM_CPU | Normal interrupt pulse per CPU |
| crit_o | output | NUM_CPU | Critical interrupt pulse per CPU |
| crit_act_o | output | NUM_SRC | Per-source activity pulse on critical delivery |

## Verification
The bench writes words that set both normal and critical bits. A decoder that let normal bits leak would pulse int_o alongside crit_o. It also sets stray bits outside the mask; a decoder that forgot the mask would then deliver where none is expected. Priority is tested at equality, and with per-CPU task priorities that split the bitmap, because an off-by-one comparison would let the equal case through. Round-robin is followed across a wrap and across an empty-bitmap strobe. A picker that began at the last CPU rather than the next one, or that moved its index on an empty search, would then choose the wrong CPU on the following strobe.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int REG_W = 32;

  typedef enum logic {
    CLS_NORMAL = 1'b0,
    CLS_CRIT   = 1'b1
  } out_class_e;

  // bits kept on a destination write
  function automatic logic [REG_W-1:0] keep_mask(int n, bit crit_en, int ep_bit);
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < REG_W; b++) begin
      if (b < n) m[b] = 1'b1;
      if (crit_en && b >= ep_bit - n && b <= ep_bit) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_dest_reg.sv
module irq_dest_reg
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int EP_BIT  = 31,
  parameter bit CRIT_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   data_i,
  output logic [NUM_CPU-1:0] bitmap_o,
  output out_class_e         class_o
);
  localparam logic [REG_W-1:0] KEEP = keep_mask(NUM_CPU, CRIT_EN, EP_BIT);
  localparam int CI0 = EP_BIT - 1;

  logic [REG_W-1:0]   kept;
  logic [NUM_CPU-1:0] crit_map;
  logic [NUM_CPU-1:0] norm_map;
  logic [NUM_CPU-1:0] bitmap_d;
  out_class_e         class_d;

  assign kept     = data_i & KEEP;
  assign norm_map = kept[NUM_CPU-1:0];

  // critical field is bit-reversed: CPU i sits at CI0 - i
  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) crit_map[i] = kept[CI0-i];
  end

  generate
    if (CRIT_EN) begin : g_crit
      always_comb begin
        if (|crit_map) begin
          class_d  = CLS_CRIT;
          bitmap_d = crit_map;
        end else begin
          class_d  = CLS_NORMAL;
          bitmap_d = norm_map;
        end
      end
    end else begin : g_plain
      assign class_d  = CLS_NORMAL;
      assign bitmap_d = norm_map;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bitmap_o <= '0;
      class_o  <= CLS_NORMAL;
    end else if (wr_i) begin
      bitmap_o <= bitmap_d;
      class_o  <= class_d;
    end
  end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int NUM_CPU = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [NUM_CPU-1:0] bitmap_i,
  input  logic [CPU_W-1:0]   last_i,
  output logic               found_o,
  output logic [CPU_W-1:0]   idx_o,
  output logic [NUM_CPU-1:0] onehot_o
);
  always_comb begin
    int c;
    found_o = 1'b0;
    idx_o   = last_i;
    for (int k = 1; k <= NUM_CPU; k++) begin
      c = (int'(last_i) + k) % NUM_CPU;
      if (!found_o && bitmap_i[c]) begin
        found_o = 1'b1;
        idx_o   = CPU_W'(c);
      end
    end
    onehot_o = '0;
    if (found_o) onehot_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/irq_src_route.sv
module irq_src_route
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pend_i,
  input  logic                      dist_i,
  input  logic [PRIO_W-1:0]         prio_i,
  input  logic [NUM_CPU*PRIO_W-1:0] task_prio_i,
  input  logic [NUM_CPU-1:0]        bitmap_i,
  input  out_class_e                class_i,
  output logic [NUM_CPU-1:0]        int_req_o,
  output logic [NUM_CPU-1:0]        crit_req_o,
  output logic                      act_o
);
  logic [CPU_W-1:0]   last_q;
  logic [CPU_W-1:0]   pick_idx;
  logic [NUM_CPU-1:0] pick_oh;
  logic               pick_found;
  logic [NUM_CPU-1:0] target;
  logic [NUM_CPU-1:0] prio_ok;

  irq_rr_pick #(.NUM_CPU(NUM_CPU)) u_pick (
    .bitmap_i (bitmap_i),
    .last_i   (last_q),
    .found_o  (pick_found),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_prio
    assign prio_ok[c] = prio_i > task_prio_i[c*PRIO_W +: PRIO_W];
  end

  assign target     = pend_i ? (dist_i ? pick_oh : bitmap_i) : '0;
  assign crit_req_o = (class_i == CLS_CRIT) ? target : '0;
  assign int_req_o  = (class_i == CLS_NORMAL) ? (target & prio_ok) : '0;
  assign act_o      = |crit_req_o;

  // last-served moves on every distributed selection, filtered or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           last_q <= '0;
    else if (pend_i && dist_i && pick_found) last_q <= pick_idx;
  end
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4,
  parameter bit CRIT_EN = 1'b1,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SRC_W-1:0]          wr_src_i,
  input  logic [31:0]               wr_data_i,
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        mode_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_CPU*PRIO_W-1:0] task_prio_i,
  output logic [NUM_CPU-1:0]        int_o,
  output logic [NUM_CPU-1:0]        crit_o,
  output logic [NUM_SRC-1:0]        crit_act_o
);
  localparam int EP_BIT = 31;

  logic [NUM_CPU-1:0] int_req  [NUM_SRC];
  logic [NUM_CPU-1:0] crit_req [NUM_SRC];
  logic [NUM_SRC-1:0] act_req;
  logic [NUM_CPU-1:0] int_any;
  logic [NUM_CPU-1:0] crit_any;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [NUM_CPU-1:0] bitmap;
    out_class_e         cls;

    irq_dest_reg #(
      .NUM_CPU (NUM_CPU),
      .EP_BIT  (EP_BIT),
      .CRIT_EN (CRIT_EN)
    ) u_dest (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i && (wr_src_i == SRC_W'(s))),
      .data_i   (wr_data_i),
      .bitmap_o (bitmap),
      .class_o  (cls)
    );

    irq_src_route #(
      .NUM_CPU (NUM_CPU),
      .PRIO_W  (PRIO_W)
    ) u_route (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pend_i      (pend_i[s]),
      .dist_i      (mode_i[s]),
      .prio_i      (prio_i[s*PRIO_W +: PRIO_W]),
      .task_prio_i (task_prio_i),
      .bitmap_i    (bitmap),
      .class_i     (cls),
      .int_req_o   (int_req[s]),
      .crit_req_o  (crit_req[s]),
      .act_o       (act_req[s])
    );
  end

  always_comb begin
    int_any  = '0;
    crit_any = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      int_any  |= int_req[s];
      crit_any |= crit_req[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o      <= '0;
      crit_o     <= '0;
      crit_act_o <= '0;
    end else begin
      int_o      <= int_any;
      crit_o     <= crit_any;
      crit_act_o <= act_req;
    end
  end
endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
  parameter int NUM_SRC = 4,
  parameter int NUM_CPU = 4,
  parameter int PRIO_W  = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_SRC-1:0]        pend_i,
  input logic [NUM_SRC-1:0]        mode_i,
  input logic [NUM_CPU*PRIO_W-1:0] task_prio_i,
  input logic [NUM_CPU-1:0]        int_o,
  input logic [NUM_CPU-1:0]        crit_o,
  input logic [NUM_SRC-1:0]        crit_act_o
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (int_o == '0 && crit_o == '0 && crit_act_o == '0));

  // R6
  act_has_crit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_act_o != '0) |-> (crit_o != '0));

  // R9
  dist_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(pend_i) == 1 && (pend_i & mode_i) == pend_i)
      |=> $onehot0(int_o | crit_o));

  // R7
  max_task_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&task_prio_i) |=> (int_o == '0));
endmodule

bind irq_dest_router irq_dest_router_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CPU (NUM_CPU),
  .PRIO_W  (PRIO_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pend_i      (pend_i),
  .mode_i      (mode_i),
  .task_prio_i (task_prio_i),
  .int_o       (int_o),
  .crit_o      (crit_o),
  .crit_act_o  (crit_act_o)
);

// File: tb/irq_dest_router_test.sv
`timescale 1ns/1ps
module irq_dest_router_test;
  localparam int NS = 4;
  localparam int NC = 4;
  localparam int PW = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            wr_en_i;
  logic [1:0]      wr_src_i;
  logic [31:0]     wr_data_i;
  logic [NS-1:0]   pend_i;
  logic [NS-1:0]   mode_i;
  logic [NS*PW-1:0] prio_i;
  logic [NC*PW-1:0] task_prio_i;
  logic [NC-1:0]   int_o;
  logic [NC-1:0]   crit_o;
  logic [NS-1:0]   crit_act_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  irq_dest_router #(.NUM_SRC(NS), .NUM_CPU(NC), .PRIO_W(PW)) uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_src_i, .wr_data_i, .pend_i, .mode_i,
    .prio_i, .task_prio_i, .int_o, .crit_o, .crit_act_o
  );

  typedef struct packed {
    logic [1:0]  src;
    logic [31:0] data;
    logic [3:0]  prio;
    logic [15:0] tp;
    logic [3:0]  e_int;
    logic [3:0]  e_crit;
    logic [3:0]  req;
  } vec_t;

  // directed-mode vectors; task priority packed {cpu3,cpu2,cpu1,cpu0}
  localparam vec_t VEC [8] = '{
    '{2'd0, 32'h0000_0005, 4'd5, 16'h0000, 4'b0101, 4'b0000, 4'd5},  // R5 R8
    '{2'd1, 32'h4000_0000, 4'd0, 16'hFFFF, 4'b0000, 4'b0001, 4'd3},  // R3 R6
    '{2'd2, 32'h1800_000F, 4'd9, 16'h0000, 4'b0000, 4'b1100, 4'd4},  // R4
    '{2'd3, 32'h0000_0100, 4'd9, 16'h0000, 4'b0000, 4'b0000, 4'd2},  // R2
    '{2'd0, 32'h0010_000A, 4'd9, 16'h0000, 4'b1010, 4'b0000, 4'd2},  // R2
    '{2'd1, 32'h0000_000F, 4'd3, 16'h3333, 4'b0000, 4'b0000, 4'd7},  // R7 equal
    '{2'd2, 32'h0000_000F, 4'd4, 16'h3333, 4'b1111, 4'b0000, 4'd7},  // R7 above
    '{2'd3, 32'h0000_000F, 4'd5, 16'h6540, 4'b0011, 4'b0000, 4'd7}   // R7 per CPU
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int src, input logic [31:0] d);
    wr_en_i   = 1'b1;
    wr_src_i  = 2'(src);
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic fire(input int src, input logic m, input logic [3:0] p,
                      input logic [3:0] e_int, input logic [3:0] e_crit, string tag);
    mode_i[src]          = m;
    prio_i[src*PW +: PW] = p;
    pend_i[src]          = 1'b1;
    @(negedge clk_i);
    pend_i = '0;
    check({tag, " int"},  32'(int_o),  32'(e_int));
    check({tag, " crit"}, 32'(crit_o), 32'(e_crit));
    check({tag, " act"},  32'(crit_act_o[src]), 32'(|e_crit));
    @(negedge clk_i);
    check({tag, " R11 pulse end"}, 32'({int_o, crit_o}), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_src_i = '0; wr_data_i = '0;
    pend_i = '0; mode_i = '0; prio_i = '0; task_prio_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 reset int",  32'(int_o), 32'd0);
    check("R1 reset crit", 32'(crit_o), 32'd0);
    fire(0, 1'b0, 4'd15, 4'b0000, 4'b0000, "R1 unwritten directed");
    fire(1, 1'b1, 4'd15, 4'b0000, 4'b0000, "R1 unwritten distributed");

    for (int i = 0; i < 8; i++) begin
      task_prio_i = VEC[i].tp;
      wr(int'(VEC[i].src), VEC[i].data);
      fire(int'(VEC[i].src), 1'b0, VEC[i].prio, VEC[i].e_int, VEC[i].e_crit,
           $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // fresh reset for round-robin state
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    task_prio_i = '0;

    // R9: bitmap {0,1,3}, last starts at 0
    wr(1, 32'h0000_000B);
    fire(1, 1'b1, 4'd8, 4'b0010, 4'b0000, "R9 rr first");
    fire(1, 1'b1, 4'd8, 4'b1000, 4'b0000, "R9 rr second");
    fire(1, 1'b1, 4'd8, 4'b0001, 4'b0000, "R9 rr wrap");
    fire(1, 1'b1, 4'd8, 4'b0010, 4'b0000, "R9 rr fourth");

    // R10: empty bitmap leaves last at 1
    wr(1, 32'h0000_0000);
    fire(1, 1'b1, 4'd8, 4'b0000, 4'b0000, "R10 empty");
    wr(1, 32'h0000_000B);
    fire(1, 1'b1, 4'd8, 4'b1000, 4'b0000, "R10 index kept");

    // R9 R6: critical distributed over CPU1,CPU2 under max task priority
    task_prio_i = 16'hFFFF;
    wr(2, 32'h3000_0000);
    fire(2, 1'b1, 4'd0, 4'b0000, 4'b0010, "R9 crit rr first");
    fire(2, 1'b1, 4'd0, 4'b0000, 4'b0100, "R9 crit rr second");
    fire(2, 1'b1, 4'd0, 4'b0000, 4'b0010, "R6 crit rr wrap");
    task_prio_i = '0;

    // R8: two directed sources in one cycle
    wr(0, 32'h0000_0001);
    wr(3, 32'h0000_0008);
    mode_i = '0;
    prio_i = {4'd7, 4'd7, 4'd7, 4'd7};
    pend_i = 4'b1001;
    @(negedge clk_i);
    pend_i = '0;
    check("R8 merged int", 32'(int_o), 32'h9);
    @(negedge clk_i);
    check("R11 merged end", 32'(int_o), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule